// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table indexed by the low bits of the branch address holds, for every slot, a small group of saturating counters. A shift register of the most recent resolved outcomes picks which counter in the group speaks for the branch. The same history therefore lets one static branch learn a different bias for each recent path through the program. With `HIST_W` history bits and `CTR_W`-bit counters, each address slot holds 2^`HIST_W` counters. The default sizing is two history bits, two-bit counters and 1024 address slots.

The fetch side presents a branch address and gets a direction back in the same cycle, with no clock edge in the path. The execute side later reports the address and the real outcome. That report trains the one counter chosen by the address and by the history as it stood before the report. Then the outcome is shifted into the history. Setting `HIST_W` to 0 turns the block into a plain per-address counter table.

Top module: `corr_bpred`

## Requirements
- R1: The counter used for a lookup or an update sits in the address slot given by R7. Within that slot it is the one numbered by the current global history value, so different histories use different counters.
- R2: `lookup_taken` is the most significant bit of the selected counter (1 = taken). It follows `lookup_pc` combinationally.
- R3: A resolve changes only the single counter selected for it. Every other counter, in the same slot or in any other slot, keeps its value.
- R4: With `HIST_W` = 0 the block is a plain table with one counter per address slot, and past outcomes of other branches have no effect on it.
- R5: For `CTR_W` ≥ 2, a taken outcome adds one to the counter and a not-taken outcome subtracts one. The counter stops at 2^`CTR_W`−1 and at 0.
- R6: For `CTR_W` = 1, the counter bit is inverted when its prediction was wrong and kept when it was right.
- R7: The address slot is `pc[IDX_W+1:2]`, where IDX_W = log2(`ENTRIES`). Address bits 1:0 and all bits above IDX_W+1 are ignored, so such addresses alias.
- R8: Each resolve shifts the history left by one, and the outcome enters at bit 0 (1 = taken). The history holds its value when no resolve occurs.
- R9: During and after a reset, every counter holds 2^(`CTR_W`−1)−1 (0 when `CTR_W` = 1) and the history is all zero. Every lookup then predicts not taken.
- R10: A resolve takes effect at the clock edge. It uses the history held before that edge. A lookup in the same cycle still sees the values from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_pc | input | PC_W | Address of the branch being fetched |
| lookup_taken | output | 1 | Predicted direction, 1 = taken |
| resolve_valid | input | 1 | A resolved branch is reported this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench runs three small configurations side by side: two history bits, no history, and one history bit with one-bit counters. It checks every prediction against a model that selects and saturates counters arithmetically.

The directed cases cover the following:
- A branch trained under one history must not predict from that counter once the history has moved. A design that ignored the history, or used the history after the shift, would predict taken where not taken is due.
- Long runs of the same outcome drive counters against both limits. A counter that wraps around turns a strong bias into its opposite.
- Addresses that differ only below bit 2 or above the index must share a counter. A wrong index slice would split them or would alias the wrong addresses.
- A lookup and a resolve to the same address in one cycle must return the value from before the update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Weakly-not-taken start value for a counter of the given width
  function automatic int unsigned ctr_init(input int unsigned w);
    return (w <= 1) ? 0 : ((1 << (w - 1)) - 1);
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 2,
  parameter int HW     = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [HW-1:0] hist_o
);
  generate
    if (HIST_W == 0) begin : g_none
      assign hist_o = '0;
    end else begin : g_reg
      logic [HW-1:0] hist_q;
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HW-2:0], shift_bit};
      end
      assign hist_o = hist_q;

      p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));
      p_hist_lsb_r8: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(shift_bit));
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] ctr_i,
  input  logic             taken_i,
  output logic [CTR_W-1:0] ctr_o
);
  localparam logic [CTR_W-1:0] CMAX = '1;

  generate
    if (CTR_W == 1) begin : g_bit
      // invert on a wrong guess, keep on a right one
      assign ctr_o = (ctr_i != taken_i) ? ~ctr_i : ctr_i;
      always_comb begin
        p_flip_r6: assert (ctr_o == taken_i);
      end
    end else begin : g_sat
      always_comb begin
        if (taken_i) ctr_o = (ctr_i == CMAX) ? ctr_i : ctr_i + 1'b1;
        else         ctr_o = (ctr_i == '0)   ? ctr_i : ctr_i - 1'b1;
      end
      always_comb begin
        if (taken_i && ctr_i == CMAX) p_sat_top_r5: assert (ctr_o == CMAX);
        if (!taken_i && ctr_i == '0)  p_sat_bot_r5: assert (ctr_o == '0);
        p_step_r5: assert (ctr_o == ctr_i || ctr_o == ctr_i + 1'b1 || ctr_o + 1'b1 == ctr_i);
      end
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int DEPTH = 4096,
  parameter int CTR_W = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_addr,
  output logic [CTR_W-1:0] rd_data,
  input  logic [AW-1:0]    wr_addr,
  output logic [CTR_W-1:0] wr_cur,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_data
);
  localparam logic [CTR_W-1:0] INIT = CTR_W'(bp_pkg::ctr_init(CTR_W));

  logic [CTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
  assign wr_cur  = mem[wr_addr];

  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
  p_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> mem[$past(rd_addr)] == $past(rd_data));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 1024,
  parameter int HIST_W  = 2,
  parameter int CTR_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            lookup_taken,
  input  logic            resolve_valid,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int HW    = (HIST_W > 0) ? HIST_W : 1;
  localparam int AW    = IDX_W + HIST_W;
  localparam int DEPTH = ENTRIES << HIST_W;

  logic [HW-1:0]    hist;
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [AW-1:0]    lk_addr, rs_addr;
  logic [CTR_W-1:0] lk_ctr, rs_ctr, rs_next;

  assign lk_idx = lookup_pc[IDX_W+1:2];
  assign rs_idx = resolve_pc[IDX_W+1:2];

  generate
    if (HIST_W == 0) begin : g_flat
      assign lk_addr = lk_idx;
      assign rs_addr = rs_idx;
    end else begin : g_corr
      assign lk_addr = {hist[HIST_W-1:0], lk_idx};
      assign rs_addr = {hist[HIST_W-1:0], rs_idx};
    end
  endgenerate

  bp_ghr #(.HIST_W(HIST_W), .HW(HW)) ghr_i (
    .clk(clk), .rst(rst), .shift_en(resolve_valid),
    .shift_bit(resolve_taken), .hist_o(hist)
  );

  bp_ctr_table #(.DEPTH(DEPTH), .CTR_W(CTR_W), .AW(AW)) tbl_i (
    .clk(clk), .rst(rst), .rd_addr(lk_addr), .rd_data(lk_ctr),
    .wr_addr(rs_addr), .wr_cur(rs_ctr), .wr_en(resolve_valid), .wr_data(rs_next)
  );

  bp_ctr_next #(.CTR_W(CTR_W)) nxt_i (
    .ctr_i(rs_ctr), .taken_i(resolve_taken), .ctr_o(rs_next)
  );

  assign lookup_taken = lk_ctr[CTR_W-1];

  p_reset_nt_r9: assert property (@(posedge clk) $past(rst) && rst |-> !lookup_taken);
endmodule

// File: tb/corr_bpred_tb_top.sv
`timescale 1ns/1ps
module corr_bpred_tb_top;
  localparam int E = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] lookup_pc = '0, resolve_pc = '0;
  logic resolve_valid = 1'b0, resolve_taken = 1'b0;
  logic pred [3];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  corr_bpred #(.PC_W(16), .ENTRIES(E), .HIST_W(2), .CTR_W(2)) dut_i (
    .clk(clk), .rst(rst), .lookup_pc(lookup_pc), .lookup_taken(pred[0]),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken));
  corr_bpred #(.PC_W(16), .ENTRIES(E), .HIST_W(0), .CTR_W(2)) dut_m0_i (
    .clk(clk), .rst(rst), .lookup_pc(lookup_pc), .lookup_taken(pred[1]),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken));
  corr_bpred #(.PC_W(16), .ENTRIES(E), .HIST_W(1), .CTR_W(1)) dut_n1_i (
    .clk(clk), .rst(rst), .lookup_pc(lookup_pc), .lookup_taken(pred[2]),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken));

  // reference model: counter groups per configuration
  int mh [3] = '{2, 0, 1};
  int mn [3] = '{2, 2, 1};
  int mctr [3][32];
  int mhist [3];

  function automatic int slot(input int k, input int pc);
    return (mhist[k] & ((1 << mh[k]) - 1)) * E + ((pc >> 2) % E);
  endfunction

  function automatic int ref_pred(input int k, input int pc);
    return (mctr[k][slot(k, pc)] >> (mn[k] - 1)) & 1;
  endfunction

  task automatic ref_update(input int k, input int pc, input bit t);
    int s, c;
    s = slot(k, pc);
    c = mctr[k][s];
    if (mn[k] == 1) c = (c != int'(t)) ? 1 - c : c;
    else if (t)     c = (c == (1 << mn[k]) - 1) ? c : c + 1;
    else            c = (c == 0) ? 0 : c - 1;
    mctr[k][s] = c;
    mhist[k] = ((mhist[k] << 1) | int'(t)) & ((1 << mh[k]) - 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; resolve_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      mhist[k] = 0;
      for (int i = 0; i < 32; i++) mctr[k][i] = (mn[k] == 1) ? 0 : (1 << (mn[k] - 1)) - 1;
    end
  endtask

  task automatic step(input int lpc, input bit rv, input int rpc, input bit rt, input string tag);
    @(negedge clk);
    lookup_pc = lpc[15:0]; resolve_valid = rv;
    resolve_pc = rpc[15:0]; resolve_taken = rt;
    #1;
    for (int k = 0; k < 3; k++) begin
      n_chk++;
      if (int'(pred[k]) != ref_pred(k, lpc)) begin
        n_fail++;
        $display("FAIL %s cfg%0d pc=%h actual=%0d expected=%0d", tag, k, lpc, pred[k], ref_pred(k, lpc));
      end
    end
    @(posedge clk);
    if (rv) for (int k = 0; k < 3; k++) ref_update(k, rpc, rt);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lfsr;
    do_reset();
    // R9: every slot predicts not taken after reset
    for (int p = 0; p < 64; p += 4) step(p, 1'b0, 0, 1'b0, "R9");

    // R1/R4: train A once; history moves so the correlated table reads a fresh counter
    step('h40, 1'b1, 'h40, 1'b1, "R1/R4");
    step('h40, 1'b0, 0, 1'b0, "R1/R4");
    step('h40, 1'b1, 'h80, 1'b1, "R1/R4");
    step('h40, 1'b0, 0, 1'b0, "R1/R4");

    // R6: one-bit counters flip only on wrong guesses
    do_reset();
    for (int i = 0; i < 8; i++) step('h24, 1'b1, 'h24, (i % 3) != 0, "R6");
    step('h24, 1'b0, 0, 1'b0, "R6");

    // R5: run into both limits
    do_reset();
    for (int i = 0; i < 10; i++) step('h10, 1'b1, 'h10, 1'b1, "R5");
    step('h10, 1'b1, 'h10, 1'b0, "R5");
    step('h10, 1'b1, 'h30, 1'b1, "R5");
    step('h10, 1'b0, 0, 1'b0, "R5");
    for (int i = 0; i < 10; i++) step('h10, 1'b1, 'h10, 1'b0, "R5");
    step('h10, 1'b1, 'h10, 1'b1, "R5");
    step('h10, 1'b0, 0, 1'b0, "R5");

    // R7: low two bits and bits above the index alias
    do_reset();
    for (int i = 0; i < 6; i++) step('h0B, 1'b1, 'h08 + (i % 4), 1'b1, "R7");
    for (int i = 0; i < 6; i++) step('h28 + 32 * i, 1'b1, 'h28 + 64 * i, 1'b1, "R7");
    step('h0C, 1'b0, 0, 1'b0, "R7");

    // R10: lookup and resolve of the same branch in one cycle
    do_reset();
    for (int i = 0; i < 12; i++) step('h1C, 1'b1, 'h1C, (i % 4) != 3, "R10");

    // R1/R2/R3/R8: pseudo-random sweep over aliasing addresses and outcomes
    do_reset();
    lfsr = 32'h1ACE;
    for (int i = 0; i < 1500; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step((lfsr & 'h3F), (lfsr >> 6) % 4 != 0, ((lfsr >> 8) & 'h3F), ((lfsr >> 14) % 3) != 0,
           "R1/R2/R3/R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule